// File: doc/BRIEF.md
# Legal-Instruction Candidate Selector

After an uncorrectable double-bit error, the surrounding recovery logic produces a short list of candidate 32-bit messages. Each candidate is a codeword at equal distance from the corrupted word. This block reads that list as a stream and treats every candidate as an instruction word. It drops each candidate whose encoding is not a legal instruction. For each surviving candidate it looks up a weight: how often that candidate's operation occurs in the running program. The heaviest survivor becomes the recovery target.

When the candidate marked last has been accepted, the block registers its result. The result is the chosen message, the number of legal candidates, and a flag that is raised when nothing survived.

The legality masks and the per-operation weights are loaded by software through a narrow register write port. The statistics are gathered elsewhere.

Top module: `cand_select`

## Requirements
- R1: The opcode is bits [31:26] of a candidate. A candidate whose opcode has a 0 in the 64-bit opcode mask is illegal. It is neither counted nor chosen.
- R2: When the opcode is 0x00, the candidate must also have a 1 in the 64-bit function mask at the index held in bits [5:0]. Its weight index is 64 plus those bits.
- R3: When the opcode is 0x11, the candidate must also have a 1 in the 32-bit format mask at the index held in bits [25:21]. Its weight index is 128 plus those bits.
- R4: For any other opcode, legality depends only on the opcode mask, and the weight index is the opcode itself. The remaining bits never affect legality.
- R5: Among the legal candidates of a stream, the one with the largest 16-bit weight is reported.
- R6: A tie-break bit is bit 0 of a 16-bit shift register. The register is seeded with 0xACE1 during reset. On every clock after reset it shifts left, taking in the XOR of bits 15, 13, 12 and 10 as its new bit 0. The first legal candidate of a stream is always taken. A later legal candidate with a weight equal to the best so far replaces it only when the tie-break bit is 1 in the cycle the candidate is accepted.
- R7: The done output is high for exactly the one cycle that follows acceptance of a candidate flagged last. In that cycle, legal_count equals the number of legal candidates in the stream.
- R8: If a stream holds no legal candidate, then at done the unrecoverable output is 1, legal_count is 0, result_valid is 0 and result_msg is 0. Otherwise unrecoverable is 0 and result_valid is 1.
- R9: Register writes use the following addresses: 0 to 159 are weights. 160 to 163 are the opcode mask in 16-bit pieces, lowest piece first. 164 to 167 are the function mask, in the same order. 168 to 169 are the format mask. in_ready is low in any cycle with a write, and a candidate offered in that cycle is not taken.
- R10: After reset, done, result_valid, unrecoverable, legal_count and result_msg are 0, and all masks and weights are 0.
- R11: result_msg, result_valid, legal_count and unrecoverable change only in a cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Candidate present |
| in_ready | output | 1 | Candidate can be taken this cycle |
| in_msg | input | 32 | Candidate message |
| in_last | input | 1 | Final candidate of the stream |
| done | output | 1 | One-cycle result strobe |
| result_valid | output | 1 | result_msg holds a chosen candidate |
| result_msg | output | 32 | Chosen recovery target |
| legal_count | output | 8 | Number of legal candidates in the stream |
| unrecoverable | output | 1 | No candidate was legal |

## Verification
The hardest situation to reach is a run of candidates with equal weights. There, the outcome depends on the tie-break register's state in each acceptance cycle, and that state is never visible at the ports. The bench tracks the register from the end of reset in its own model. It then sends several streams of same-operation candidates and compares every result against that model.

A second hard case is a register write that collides with an offered candidate. A write that raises one opcode's weight is driven in the same cycle as a candidate of that opcode, which must wait and then win.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int MSG_W    = 32;
    localparam int OPC_W    = 6;
    localparam int FN_W     = 6;
    localparam int FMT_W    = 5;
    localparam int OPC_LSB  = 26;
    localparam int FMT_LSB  = 21;
    localparam int FN_LSB   = 0;
    localparam int OP_N     = 1 << OPC_W;
    localparam int FN_N     = 1 << FN_W;
    localparam int FMT_N    = 1 << FMT_W;
    localparam int FN_BASE  = OP_N;
    localparam int FMT_BASE = OP_N + FN_N;
    localparam int IDX_N    = FMT_BASE + FMT_N;
    localparam int IDX_W    = $clog2(IDX_N);
    localparam logic [OPC_W-1:0] OPC_REG = 6'h00;
    localparam logic [OPC_W-1:0] OPC_FLT = 6'h11;

    typedef struct packed {
        logic             legal;
        logic [IDX_W-1:0] idx;
    } dec_t;
endpackage

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [FN_W-1:0]  fn,
    input  logic [FMT_W-1:0] fmt,
    input  logic [OP_N-1:0]  op_mask,
    input  logic [FN_N-1:0]  fn_mask,
    input  logic [FMT_N-1:0] fmt_mask,
    output dec_t             dec
);
    always_comb begin
        dec.legal = op_mask[opc];
        dec.idx   = IDX_W'(opc);
        if (opc == OPC_REG) begin
            dec.legal = op_mask[opc] & fn_mask[fn];
            dec.idx   = IDX_W'(FN_BASE) + IDX_W'(fn);
        end else if (opc == OPC_FLT) begin
            dec.legal = op_mask[opc] & fmt_mask[fmt];
            dec.idx   = IDX_W'(FMT_BASE) + IDX_W'(fmt);
        end
    end
endmodule

// File: rtl/csel_tables.sv
module csel_tables
    import csel_pkg::*;
#(
    parameter int W_W = 16,
    parameter int AW  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [W_W-1:0]   wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W_W-1:0]   rd_weight,
    output logic [OP_N-1:0]  op_mask,
    output logic [FN_N-1:0]  fn_mask,
    output logic [FMT_N-1:0] fmt_mask
);
    localparam int OP_CH    = (OP_N + W_W - 1) / W_W;
    localparam int FN_CH    = (FN_N + W_W - 1) / W_W;
    localparam int FMT_CH   = (FMT_N + W_W - 1) / W_W;
    localparam int OPM_BASE = IDX_N;
    localparam int FNM_BASE = OPM_BASE + OP_CH;
    localparam int FMM_BASE = FNM_BASE + FN_CH;

    logic [W_W-1:0]        w_arr [IDX_N];
    logic [OP_CH*W_W-1:0]  opm_flat;
    logic [FN_CH*W_W-1:0]  fnm_flat;
    logic [FMT_CH*W_W-1:0] fmm_flat;

    for (genvar g = 0; g < IDX_N; g++) begin : g_wt
        logic [W_W-1:0] ent_d, ent_q;
        always_comb begin
            ent_d = ent_q;
            if (we && addr == AW'(g)) ent_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (rst) ent_q <= '0;
            else     ent_q <= ent_d;
        end
        assign w_arr[g] = ent_q;
    end

    for (genvar c = 0; c < OP_CH; c++) begin : g_opm
        logic [W_W-1:0] pc_d, pc_q;
        always_comb begin
            pc_d = pc_q;
            if (we && addr == AW'(OPM_BASE + c)) pc_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (rst) pc_q <= '0;
            else     pc_q <= pc_d;
        end
        assign opm_flat[c*W_W +: W_W] = pc_q;
    end

    for (genvar c = 0; c < FN_CH; c++) begin : g_fnm
        logic [W_W-1:0] pc_d, pc_q;
        always_comb begin
            pc_d = pc_q;
            if (we && addr == AW'(FNM_BASE + c)) pc_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (rst) pc_q <= '0;
            else     pc_q <= pc_d;
        end
        assign fnm_flat[c*W_W +: W_W] = pc_q;
    end

    for (genvar c = 0; c < FMT_CH; c++) begin : g_fmm
        logic [W_W-1:0] pc_d, pc_q;
        always_comb begin
            pc_d = pc_q;
            if (we && addr == AW'(FMM_BASE + c)) pc_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (rst) pc_q <= '0;
            else     pc_q <= pc_d;
        end
        assign fmm_flat[c*W_W +: W_W] = pc_q;
    end

    assign op_mask   = opm_flat[OP_N-1:0];
    assign fn_mask   = fnm_flat[FN_N-1:0];
    assign fmt_mask  = fmm_flat[FMT_N-1:0];
    assign rd_weight = w_arr[rd_idx];

    // R9: a weight write at address 5 is the value read back one cycle later
    a_r9_weight_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && addr == AW'(5)) |=> (w_arr[5] == $past(wdata)));
endmodule

// File: rtl/csel_lfsr.sv
module csel_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic clk,
    input  logic rst,
    output logic tie_bit
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[W-2:0], ^(sr_q & TAPS)};
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= SEED;
        else     sr_q <= sr_d;
    end

    assign tie_bit = sr_q[0];

    // R6: the register never locks up at zero
    a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        sr_q != '0);
endmodule

// File: rtl/cand_select.sv
module cand_select
    import csel_pkg::*;
#(
    parameter int          W_W   = 16,
    parameter int          AW    = 8,
    parameter int          CNT_W = 8,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [W_W-1:0]   cfg_wdata,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [MSG_W-1:0] in_msg,
    input  logic             in_last,
    output logic             done,
    output logic             result_valid,
    output logic [MSG_W-1:0] result_msg,
    output logic [CNT_W-1:0] legal_count,
    output logic             unrecoverable
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             best_vld;
        logic [MSG_W-1:0] best_msg;
        logic [W_W-1:0]   best_w;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             res_vld;
        logic [MSG_W-1:0] res_msg;
        logic [CNT_W-1:0] res_cnt;
        logic             res_unrec;
    } st_t;

    st_t s_d, s_q;

    logic [OP_N-1:0]  op_mask;
    logic [FN_N-1:0]  fn_mask;
    logic [FMT_N-1:0] fmt_mask;
    logic [W_W-1:0]   cand_w;
    logic             tie_bit;
    dec_t             dec;
    logic             take;
    logic             wins;
    logic             nb_vld;
    logic [MSG_W-1:0] nb_msg;
    logic [W_W-1:0]   nb_w;
    logic [CNT_W-1:0] nb_cnt;

    csel_decode u_dec (
        .opc      (in_msg[OPC_LSB +: OPC_W]),
        .fn       (in_msg[FN_LSB +: FN_W]),
        .fmt      (in_msg[FMT_LSB +: FMT_W]),
        .op_mask  (op_mask),
        .fn_mask  (fn_mask),
        .fmt_mask (fmt_mask),
        .dec      (dec)
    );

    csel_tables #(.W_W(W_W), .AW(AW)) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rd_idx    (dec.idx),
        .rd_weight (cand_w),
        .op_mask   (op_mask),
        .fn_mask   (fn_mask),
        .fmt_mask  (fmt_mask)
    );

    csel_lfsr #(.W(16), .SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .tie_bit (tie_bit)
    );

    assign in_ready = ~cfg_we;
    assign take     = in_valid & in_ready;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        nb_vld   = s_q.best_vld;
        nb_msg   = s_q.best_msg;
        nb_w     = s_q.best_w;
        nb_cnt   = s_q.cnt;
        wins     = !s_q.best_vld || (cand_w > s_q.best_w) ||
                   ((cand_w == s_q.best_w) && tie_bit);
        if (take && dec.legal) begin
            nb_cnt = (s_q.cnt == CNT_MAX) ? s_q.cnt : s_q.cnt + 1'b1;
            if (wins) begin
                nb_vld = 1'b1;
                nb_msg = in_msg;
                nb_w   = cand_w;
            end
        end
        if (take && in_last) begin
            s_d.done      = 1'b1;
            s_d.res_vld   = nb_vld;
            s_d.res_msg   = nb_vld ? nb_msg : '0;
            s_d.res_cnt   = nb_cnt;
            s_d.res_unrec = !nb_vld;
            s_d.best_vld  = 1'b0;
            s_d.best_msg  = '0;
            s_d.best_w    = '0;
            s_d.cnt       = '0;
        end else if (take) begin
            s_d.best_vld = nb_vld;
            s_d.best_msg = nb_msg;
            s_d.best_w   = nb_w;
            s_d.cnt      = nb_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign done          = s_q.done;
    assign result_valid  = s_q.res_vld;
    assign result_msg    = s_q.res_msg;
    assign legal_count   = s_q.res_cnt;
    assign unrecoverable = s_q.res_unrec;

    // R7: accepting a last candidate raises done on the next cycle
    a_r7_done_follows_last: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> done);

    // R7: done never appears without a preceding last acceptance
    a_r7_done_has_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid && in_ready && in_last));

    // R8: unrecoverable and result_valid are opposites at done
    a_r8_flag_excl: assert property (@(posedge clk) disable iff (rst)
        done |-> (unrecoverable != result_valid));

    // R8: an unrecoverable stream reports zero count and zero message
    a_r8_unrec_zeroed: assert property (@(posedge clk) disable iff (rst)
        (done && unrecoverable) |-> (legal_count == '0 && result_msg == '0));

    // R11: result outputs hold between strobes
    a_r11_hold_result: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result_msg) && $stable(legal_count) &&
                   $stable(unrecoverable) && $stable(result_valid)));

    // R1: a counted candidate has its opcode enabled in the mask
    a_r1_legal_needs_opcode: assert property (@(posedge clk) disable iff (rst)
        (take && dec.legal) |-> op_mask[in_msg[OPC_LSB +: OPC_W]]);
endmodule

// File: tb/sim_cand_select.sv
module sim_cand_select;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_msg = '0;
    logic        in_last = 1'b0;
    logic        done, result_valid, unrecoverable;
    logic [31:0] result_msg;
    logic [7:0]  legal_count;

    int total = 0;
    int bad   = 0;
    bit fin   = 0;

    cand_select u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_msg(in_msg), .in_last(in_last), .done(done),
        .result_valid(result_valid), .result_msg(result_msg),
        .legal_count(legal_count), .unrecoverable(unrecoverable)
    );

    always #5 clk = ~clk;

    // reference model state
    int unsigned mw [160];
    bit          mop [64];
    bit          mfn [64];
    bit          mfm [32];
    logic [15:0] m_lfsr;
    bit          m_init = 0;
    bit          m_bv;
    logic [31:0] m_bm;
    int unsigned m_bw;
    int          m_cnt;
    bit          m_done, m_rv, m_un;
    logic [31:0] m_rm;
    int          m_rc;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void mdec(input logic [31:0] m, output bit lg, output int idx);
        int opc, fn, ft;
        opc = int'(m[31:26]);
        fn  = int'(m[5:0]);
        ft  = int'(m[25:21]);
        lg  = mop[opc];
        idx = opc;
        if (opc == 0) begin
            lg  = lg && mfn[fn];
            idx = 64 + fn;
        end else if (opc == 17) begin
            lg  = lg && mfm[ft];
            idx = 128 + ft;
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (mw[i]) mw[i] = 0;
            foreach (mop[i]) mop[i] = 0;
            foreach (mfn[i]) mfn[i] = 0;
            foreach (mfm[i]) mfm[i] = 0;
            m_lfsr = 16'hACE1;
            m_bv = 0; m_bm = 0; m_bw = 0; m_cnt = 0;
            m_done = 0; m_rv = 0; m_un = 0; m_rm = 0; m_rc = 0;
            m_init = 1;
        end else begin
            chk("R9 in_ready", {63'd0, in_ready}, {63'd0, !cfg_we});
            m_done = 0;
            if (in_valid && !cfg_we) begin
                bit lg;
                int idx;
                mdec(in_msg, lg, idx);
                if (lg) begin
                    if (m_cnt < 255) m_cnt++;
                    if (!m_bv || mw[idx] > m_bw || (mw[idx] == m_bw && m_lfsr[0])) begin
                        m_bv = 1; m_bm = in_msg; m_bw = mw[idx];
                    end
                end
                if (in_last) begin
                    m_done = 1; m_rv = m_bv; m_rm = m_bv ? m_bm : 32'd0;
                    m_rc = m_cnt; m_un = !m_bv;
                    m_bv = 0; m_bm = 0; m_bw = 0; m_cnt = 0;
                end
            end
            if (cfg_we) begin
                int a;
                a = int'(cfg_addr);
                if (a < 160) mw[a] = cfg_wdata;
                else if (a < 164) for (int b = 0; b < 16; b++) mop[(a-160)*16+b] = cfg_wdata[b];
                else if (a < 168) for (int b = 0; b < 16; b++) mfn[(a-164)*16+b] = cfg_wdata[b];
                else if (a < 170) for (int b = 0; b < 16; b++) mfm[(a-168)*16+b] = cfg_wdata[b];
            end
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
    end

    always @(negedge clk) begin
        if (m_init && !rst) begin
            chk("R7 done", {63'd0, done}, {63'd0, m_done});
            chk("R7 legal_count", {56'd0, legal_count}, 64'(m_rc));
            chk("R8 unrecoverable", {63'd0, unrecoverable}, {63'd0, m_un});
            chk("R8 result_valid", {63'd0, result_valid}, {63'd0, m_rv});
            chk("R5,R6 result_msg", {32'd0, result_msg}, {32'd0, m_rm});
        end
    end

    task automatic cfg(input int a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] m, input bit l);
        @(negedge clk);
        in_valid = 1'b1; in_msg = m; in_last = l;
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic expect_res(string tag, int cnt, bit un, bit vld, logic [31:0] m);
        @(negedge clk);
        chk({tag, " done"}, {63'd0, done}, 64'd1);
        chk({tag, " count"}, {56'd0, legal_count}, 64'(cnt));
        chk({tag, " unrec"}, {63'd0, unrecoverable}, {63'd0, un});
        chk({tag, " valid"}, {63'd0, result_valid}, {63'd0, vld});
        chk({tag, " msg"}, {32'd0, result_msg}, {32'd0, m});
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] rest);
        return {op, rest};
    endfunction

    initial begin
        #2_000_000;
        if (!fin) begin
            total++; bad++;
            $display("FAIL R7 watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] opm, fnm;
        logic [31:0] fmm, keep;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 done", {63'd0, done}, 64'd0);
        chk("R10 result_valid", {63'd0, result_valid}, 64'd0);
        chk("R10 unrec", {63'd0, unrecoverable}, 64'd0);
        chk("R10 count", {56'd0, legal_count}, 64'd0);
        chk("R10 msg", {32'd0, result_msg}, 64'd0);

        // R10: tables cleared, so any candidate is illegal before loading
        send(mk(6'h23, 26'h1), 1'b1);
        expect_res("R10 empty tables", 0, 1, 0, 32'd0);

        // load masks and weights (R9 address map)
        opm = '0;
        opm[6'h00] = 1; opm[6'h02] = 1; opm[6'h04] = 1; opm[6'h08] = 1;
        opm[6'h11] = 1; opm[6'h23] = 1; opm[6'h2B] = 1;
        fnm = '0; fnm[6'h20] = 1; fnm[6'h21] = 1; fnm[6'h08] = 1;
        fmm = '0; fmm[16] = 1; fmm[17] = 1; fmm[20] = 1;
        for (int c = 0; c < 4; c++) cfg(160 + c, opm[c*16 +: 16]);
        for (int c = 0; c < 4; c++) cfg(164 + c, fnm[c*16 +: 16]);
        for (int c = 0; c < 2; c++) cfg(168 + c, fmm[c*16 +: 16]);
        cfg(8'h23, 16'd900); cfg(8'h2B, 16'd400); cfg(8'h08, 16'd300);
        cfg(8'h02, 16'd200); cfg(8'h04, 16'd250);
        cfg(64 + 8'h20, 16'd500); cfg(64 + 8'h21, 16'd500); cfg(64 + 8'h08, 16'd50);
        cfg(128 + 16, 16'd10); cfg(128 + 17, 16'd10); cfg(128 + 20, 16'd5);

        // R1, R5: illegal opcodes dropped, heaviest legal kept
        send(mk(6'h23, 26'h0ABCDEF), 1'b0);
        send(mk(6'h01, 26'h0000010), 1'b0);
        send(mk(6'h2B, 26'h1234567), 1'b0);
        send(mk(6'h3F, 26'h3FFFFFF), 1'b1);
        expect_res("R1 R5 opcode filter", 2, 0, 1, mk(6'h23, 26'h0ABCDEF));
        keep = mk(6'h23, 26'h0ABCDEF);

        // R11: outputs hold while idle
        repeat (3) @(negedge clk);
        chk("R11 held msg", {32'd0, result_msg}, {32'd0, keep});
        chk("R11 held count", {56'd0, legal_count}, 64'd2);
        chk("R11 done low", {63'd0, done}, 64'd0);

        // R2: register type needs function mask; index 64+funct
        send({6'h00, 20'h12345, 6'h22}, 1'b0);
        send({6'h00, 20'h54321, 6'h20}, 1'b0);
        send(mk(6'h2B, 26'h0000004), 1'b1);
        expect_res("R2 funct filter", 2, 0, 1, {6'h00, 20'h54321, 6'h20});

        // R3: floating point needs format mask; index 128+fmt
        send({6'h11, 5'd3, 21'h1}, 1'b0);
        send({6'h11, 5'd16, 21'h2}, 1'b0);
        send({6'h11, 5'd20, 21'h3}, 1'b1);
        expect_res("R3 fmt filter", 2, 0, 1, {6'h11, 5'd16, 21'h2});

        // R4: other fields do not matter for ordinary opcodes
        send(mk(6'h08, 26'h3FFFFFF), 1'b0);
        send(mk(6'h23, 26'h0000000), 1'b0);
        send(mk(6'h04, 26'h2AAAAAA), 1'b1);
        expect_res("R4 free fields", 3, 0, 1, mk(6'h23, 26'h0000000));

        // R8: no legal candidate
        send(mk(6'h01, 26'h5), 1'b0);
        send({6'h00, 20'h0, 6'h3F}, 1'b0);
        send({6'h11, 5'd31, 21'h0}, 1'b1);
        expect_res("R8 unrecoverable", 0, 1, 0, 32'd0);

        // R6: ties among equal weights, checked against the model each cycle
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 6; i++)
                send(mk(6'h23, 26'(s * 16 + i)), i == 5);
            @(negedge clk);
            chk("R6 tie count", {56'd0, legal_count}, 64'd6);
            chk("R6 tie opcode", {58'd0, result_msg[31:26]}, 64'h23);
        end

        // R9: a write stalls an offered candidate, then the new weight applies
        @(negedge clk);
        in_valid = 1'b1; in_msg = mk(6'h2B, 26'h77); in_last = 1'b0;
        cfg_we = 1'b1; cfg_addr = 8'h2B; cfg_wdata = 16'd1000;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b0;
        send(mk(6'h23, 26'h88), 1'b1);
        expect_res("R9 stall and reweight", 2, 0, 1, mk(6'h2B, 26'h77));

        // R7: consecutive single-candidate streams
        send(mk(6'h02, 26'h1), 1'b1);
        expect_res("R7 single", 1, 0, 1, mk(6'h02, 26'h1));
        send(mk(6'h3E, 26'h1), 1'b1);
        expect_res("R7 single illegal", 0, 1, 0, 32'd0);
        @(negedge clk);
        chk("R7 done one cycle", {63'd0, done}, 64'd0);

        repeat (3) @(negedge clk);
        fin = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule